// File: doc/BRIEF.md
# Two-of-Seven Transition-Coded Link Endpoint

This block terminates one direction pair of an inter-chip link. Seven wires carry data and an eighth carries the acknowledge back. A packet is a stream of 4-bit nibbles closed by an end-of-packet marker. Each symbol is sent by inverting exactly two of the seven data wires. The wires are never returned to a rest level, so the new value is coded in which wires changed and not in their levels. The far side answers every symbol by inverting the acknowledge wire once. Nothing in the handshake assumes a bound on wire delay: longer wires or extra buffering slow the link but do not break it.

The transmitter takes one nibble or end marker per handshake on its local side. It inverts the matching wire pair and then withholds `tx_ready` until the acknowledge inversion has come back through a two-flop synchronizer. The receiver synchronizes the seven incoming wires and compares them with the levels it last accepted. Once two wires differ, it waits one more cycle for skew to settle and then decodes the pair. It then adopts the new levels, inverts its acknowledge and presents the nibble or end marker for one cycle. A symbol that shows more than two changed wires, or that names one of the unused pairs, is still acknowledged. It raises an error pulse, and the receiver delivers nothing further up to and including the next end marker.

Top module: `pairtoggle_link`

## Requirements
- R1: While reset is asserted and after it is released, `tx_wires` is all zero, `rx_ack_out` is 0, `tx_ready` is 1, and `rx_valid` and `rx_err` are 0 until a symbol arrives.
- R2: Each transmit handshake (`tx_valid` and `tx_ready` high at a rising edge) inverts exactly two bits of `tx_wires`. In every other cycle `tx_wires` holds its value.
- R3: Nibble value v selects the v-th wire pair (i,j) with i<j, counted from 0 in ascending lexicographic order over wire indices 0..6. So 0 is wires 0,1; 5 is wires 0,6; 6 is wires 1,2; 11 is wires 2,3; 15 is wires 3,4. End-of-packet is wires 3,5. The pairs (3,6), (4,5), (4,6) and (5,6) are unused. When `tx_eop` is 1, `tx_nibble` is ignored.
- R4: After a handshake, `tx_ready` is 0 from the next cycle on. It returns to 1 only after an inversion of `tx_ack_in` has passed a two-flop synchronizer.
- R5: When the received wires differ from the accepted levels in exactly two positions forming a used pair, the receiver pulses `rx_valid` for one cycle. The pulse carries `rx_eop`=1 for the end pair, or `rx_eop`=0 and the R3 value on `rx_nibble`. Symbols are delivered in the order sent.
- R6: `rx_ack_out` inverts exactly once per received symbol, whether the symbol is valid or invalid.
- R7: Decoding does not depend on arrival timing. The two wires of a symbol may arrive in different cycles, and the acknowledge may return after any delay; the delivered stream is unchanged.
- R8: A symbol in which three or more wires changed pulses `rx_err` for one cycle and never `rx_valid` in that cycle.
- R9: A symbol that is one of the four unused pairs pulses `rx_err` and produces no `rx_valid`.
- R10: After an `rx_err`, no symbol is delivered up to and including the next end marker. Delivery resumes with the symbol that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Local side offers a symbol |
| tx_eop | input | 1 | Offered symbol is the end marker |
| tx_nibble | input | 4 | Offered nibble value |
| tx_ready | output | 1 | Transmitter can take a symbol this cycle |
| tx_wires | output | 7 | Outgoing transition-coded data wires |
| tx_ack_in | input | 1 | Acknowledge wire from the far receiver |
| rx_wires | input | 7 | Incoming transition-coded data wires |
| rx_ack_out | output | 1 | Acknowledge wire to the far transmitter |
| rx_valid | output | 1 | One-cycle pulse: a decoded symbol is present |
| rx_eop | output | 1 | Decoded symbol is the end marker |
| rx_nibble | output | 4 | Decoded nibble value |
| rx_err | output | 1 | One-cycle pulse: an invalid symbol was received |

## Verification
The transmitter is looped back to the receiver through a wire model in the bench. The first stimulus is a packet that walks all sixteen nibble values and the end marker, with one-cycle wires and a fast acknowledge. A mistake in the pair table, in the wire-change rule or in the decode then appears as a wrong nibble or a wrong wire mask. The same traffic is then repeated with alternate data wires delayed by two extra cycles and a long acknowledge path. This separates a receiver that waits for both changes from one that decodes on the first wire, and a transmitter that waits for the acknowledge from one that runs ahead. Invalid symbols are injected on top of the loop, first a three-wire change between packets and then an unused pair in the middle of a packet. These show whether the error is flagged, whether it is still acknowledged, and whether the remainder of the packet, and only that remainder, is dropped.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

  localparam int LINES = 7;
  localparam int NIB_W = 4;
  localparam int IDX_W = 5;
  localparam int SYNC_STAGES = 2;

  localparam logic [IDX_W-1:0] EOP_IDX = IDX_W'(16);
  localparam logic [IDX_W-1:0] NO_IDX  = '1;

  typedef enum logic {
    RX_WAIT   = 1'b0,
    RX_SETTLE = 1'b1
  } rx_state_e;

  // Wire pair for symbol index idx: pairs (i,j), i<j, in lexicographic order.
  function automatic logic [LINES-1:0] pair_of(input logic [IDX_W-1:0] idx);
    logic [LINES-1:0] m;
    int k;
    m = '0;
    k = 0;
    for (int i = 0; i < LINES; i++) begin
      for (int j = i + 1; j < LINES; j++) begin
        if (k == int'(idx)) begin
          m[i] = 1'b1;
          m[j] = 1'b1;
        end
        k++;
      end
    end
    return m;
  endfunction

  // Inverse lookup: index of a two-hot mask, NO_IDX when not two-hot.
  function automatic logic [IDX_W-1:0] index_of(input logic [LINES-1:0] m);
    logic [IDX_W-1:0] r;
    logic [LINES-1:0] cand;
    int k;
    r = NO_IDX;
    k = 0;
    for (int i = 0; i < LINES; i++) begin
      for (int j = i + 1; j < LINES; j++) begin
        cand = '0;
        cand[i] = 1'b1;
        cand[j] = 1'b1;
        if (m == cand) r = IDX_W'(k);
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ptl_sync.sv
module ptl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ptl_tx.sv
module ptl_tx
  import ptl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             eop,
  input  logic [NIB_W-1:0] nibble,
  output logic             ready,
  output logic [LINES-1:0] wires,
  input  logic             ack_in
);

  logic             ack_s;
  logic             par_q, par_n;
  logic [LINES-1:0] wires_q, wires_n;
  logic             fire;
  logic [IDX_W-1:0] sym_idx;

  ptl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_in),
    .q     (ack_s)
  );

  // Ready when every launched symbol has had its acknowledge returned.
  assign ready = (ack_s == par_q);
  assign fire  = valid && ready;

  always_comb begin
    sym_idx = eop ? EOP_IDX : {{(IDX_W-NIB_W){1'b0}}, nibble};
    wires_n = wires_q;
    par_n   = par_q;
    if (fire) begin
      wires_n = wires_q ^ pair_of(sym_idx);
      par_n   = ~par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wires_q <= '0;
      par_q   <= 1'b0;
    end else if (fire) begin
      wires_q <= wires_n;
      par_q   <= par_n;
    end
  end

  assign wires = wires_q;

endmodule

// File: rtl/ptl_rx.sv
module ptl_rx
  import ptl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_s,
  output logic             ack_out,
  output logic             valid,
  output logic             eop,
  output logic [NIB_W-1:0] nibble,
  output logic             err
);

  rx_state_e        st_q, st_n;
  logic [LINES-1:0] lvl_q, lvl_n;
  logic             ack_q, ack_n;
  logic             drop_q, drop_n;
  logic             vld_q, vld_n;
  logic             eop_q, eop_n;
  logic [NIB_W-1:0] nib_q, nib_n;
  logic             err_q, err_n;
  logic [LINES-1:0] diff;
  logic [2:0]       cnt;
  logic [IDX_W-1:0] idx;
  logic             bad;

  assign diff = lines_s ^ lvl_q;
  assign cnt  = 3'($countones(diff));
  assign idx  = index_of(diff);
  assign bad  = (cnt != 3'd2) || (idx > EOP_IDX);

  always_comb begin
    st_n   = st_q;
    lvl_n  = lvl_q;
    ack_n  = ack_q;
    drop_n = drop_q;
    vld_n  = 1'b0;
    eop_n  = eop_q;
    nib_n  = nib_q;
    err_n  = 1'b0;
    case (st_q)
      RX_WAIT: begin
        if (cnt >= 3'd2) st_n = RX_SETTLE;
      end
      RX_SETTLE: begin
        st_n  = RX_WAIT;
        lvl_n = lines_s;
        ack_n = ~ack_q;
        if (bad) begin
          err_n  = 1'b1;
          drop_n = 1'b1;
        end else if (idx == EOP_IDX) begin
          vld_n  = ~drop_q;
          eop_n  = 1'b1;
          drop_n = 1'b0;
        end else begin
          vld_n = ~drop_q;
          eop_n = 1'b0;
          nib_n = idx[NIB_W-1:0];
        end
      end
      default: st_n = RX_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_WAIT;
      lvl_q  <= '0;
      ack_q  <= 1'b0;
      drop_q <= 1'b0;
      vld_q  <= 1'b0;
      eop_q  <= 1'b0;
      nib_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      lvl_q  <= lvl_n;
      ack_q  <= ack_n;
      drop_q <= drop_n;
      vld_q  <= vld_n;
      eop_q  <= eop_n;
      nib_q  <= nib_n;
      err_q  <= err_n;
    end
  end

  assign ack_out = ack_q;
  assign valid   = vld_q;
  assign eop     = eop_q;
  assign nibble  = nib_q;
  assign err     = err_q;

endmodule

// File: rtl/pairtoggle_link.sv
module pairtoggle_link
  import ptl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic             tx_eop,
  input  logic [NIB_W-1:0] tx_nibble,
  output logic             tx_ready,
  output logic [LINES-1:0] tx_wires,
  input  logic             tx_ack_in,
  input  logic [LINES-1:0] rx_wires,
  output logic             rx_ack_out,
  output logic             rx_valid,
  output logic             rx_eop,
  output logic [NIB_W-1:0] rx_nibble,
  output logic             rx_err
);

  logic             rst_core_n;
  logic [LINES-1:0] rx_lines_s;

  // Reset asserts at once, releases on a clock edge.
  ptl_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  ptl_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (rx_wires),
    .q     (rx_lines_s)
  );

  ptl_tx u_tx (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .valid  (tx_valid),
    .eop    (tx_eop),
    .nibble (tx_nibble),
    .ready  (tx_ready),
    .wires  (tx_wires),
    .ack_in (tx_ack_in)
  );

  ptl_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .lines_s (rx_lines_s),
    .ack_out (rx_ack_out),
    .valid   (rx_valid),
    .eop     (rx_eop),
    .nibble  (rx_nibble),
    .err     (rx_err)
  );

endmodule

// File: rtl/pairtoggle_link_chk.sv
module pairtoggle_link_chk
  import ptl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_eop,
  input logic [NIB_W-1:0] tx_nibble,
  input logic             tx_ready,
  input logic [LINES-1:0] tx_wires,
  input logic             tx_ack_in,
  input logic [LINES-1:0] rx_wires,
  input logic             rx_ack_out,
  input logic             rx_valid,
  input logic             rx_eop,
  input logic [NIB_W-1:0] rx_nibble,
  input logic             rx_err
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_SEND_TWO_LINES: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (tx_wires != $past(tx_wires)) |-> ($countones(tx_wires ^ $past(tx_wires)) == 2)); // R2

  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    !(tx_valid && tx_ready) |=> $stable(tx_wires)); // R2

  AST_BUSY_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (tx_valid && tx_ready) |=> !tx_ready); // R4

  AST_DELIVER_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    rx_valid |-> (rx_ack_out != $past(rx_ack_out))); // R6

  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    rx_err |-> (rx_ack_out != $past(rx_ack_out))); // R6

  AST_ERR_NO_DELIVER: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    rx_err |-> !rx_valid); // R8

endmodule

bind pairtoggle_link pairtoggle_link_chk u_chk (.*);

// File: tb/sim_pairtoggle_link.sv
module sim_pairtoggle_link;

  logic       clk;
  logic       rst_n;
  logic       tx_valid;
  logic       tx_eop;
  logic [3:0] tx_nibble;
  logic       tx_ready;
  logic [6:0] tx_wires;
  logic       tx_ack_in;
  logic [6:0] rx_wires;
  logic       rx_ack_out;
  logic       rx_valid;
  logic       rx_eop;
  logic [3:0] rx_nibble;
  logic       rx_err;

  // Wire model: per-line delay, injected corruption, delayed acknowledge.
  logic [6:0] d1, d2, d3;
  logic [6:0] skew_mask;
  logic [6:0] inj;
  logic [7:0] ackline;
  int         ack_tap;
  logic       ack_fix;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_on = 0;

  logic [4:0] exp_q [$];
  int         exp_err = 0;
  bit         dropping = 0;
  int         sym_total = 0;
  int         ack_toggles = 0;
  int         fix_pending = 0;
  logic [6:0] last_mask;
  logic [6:0] prev_tx;
  logic       prev_ack;
  logic       prev_dly;

  pairtoggle_link u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_eop     (tx_eop),
    .tx_nibble  (tx_nibble),
    .tx_ready   (tx_ready),
    .tx_wires   (tx_wires),
    .tx_ack_in  (tx_ack_in),
    .rx_wires   (rx_wires),
    .rx_ack_out (rx_ack_out),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .rx_nibble  (rx_nibble),
    .rx_err     (rx_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    d1 <= tx_wires;
    d2 <= d1;
    d3 <= d2;
    ackline <= {ackline[6:0], rx_ack_out};
  end

  assign rx_wires  = ((d1 & ~skew_mask) | (d3 & skew_mask)) ^ inj;
  assign tx_ack_in = ackline[ack_tap] ^ ack_fix;

  // Pair table taken from R3.
  function automatic logic [6:0] exp_pair(input int v);
    logic [6:0] m;
    int k;
    m = '0;
    k = 0;
    for (int i = 0; i < 7; i++)
      for (int j = i + 1; j < 7; j++) begin
        if (k == v) begin m[i] = 1'b1; m[j] = 1'b1; end
        k++;
      end
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic e, input logic [3:0] n);
    while (!tx_ready) @(negedge clk);
    tx_valid  = 1'b1;
    tx_eop    = e;
    tx_nibble = n;
    last_mask = exp_pair(e ? 16 : int'(n));
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R4", "tx_ready after send", int'(tx_ready), 0);
    sym_total++;
    if (!dropping) exp_q.push_back({e, n});
    else if (e) dropping = 0;
  endtask

  task automatic settle_idle();
    repeat (40) @(negedge clk);
  endtask

  task automatic inject(input logic [6:0] m);
    settle_idle();
    inj = inj ^ m;
    exp_err++;
    dropping = 1;
    sym_total++;
    fix_pending = 1;
    settle_idle();
  endtask

  // Per-cycle reference comparison.
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_wires !== prev_tx)
        chk(((tx_wires ^ prev_tx) == last_mask) && ($countones(tx_wires ^ prev_tx) == 2),
            "R2/R3", "tx wire change mask", int'(tx_wires ^ prev_tx), int'(last_mask));
      prev_tx = tx_wires;
      if (rx_ack_out !== prev_ack) ack_toggles++;
      prev_ack = rx_ack_out;
      if (ackline[ack_tap] !== prev_dly && fix_pending > 0) begin
        ack_fix = ~ack_fix;
        fix_pending = 0;
      end
      prev_dly = ackline[ack_tap];
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected delivery", int'({rx_eop, rx_nibble}), -1);
        end else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          chk(rx_eop == e[4], "R5", "rx_eop", int'(rx_eop), int'(e[4]));
          if (!e[4]) chk(rx_nibble == e[3:0], "R5", "rx_nibble", int'(rx_nibble), int'(e[3:0]));
        end
      end
      if (rx_err) begin
        chk(exp_err > 0, "R8/R9", "rx_err pulse", 1, 0);
        if (exp_err > 0) exp_err--;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    tx_valid = 1'b0;
    tx_eop = 1'b0;
    tx_nibble = '0;
    skew_mask = '0;
    inj = '0;
    ack_tap = 0;
    ack_fix = 1'b0;
    ackline = '0;
    d1 = '0; d2 = '0; d3 = '0;
    repeat (5) @(negedge clk);
    chk(tx_wires == 7'd0, "R1", "tx_wires in reset", int'(tx_wires), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_wires == 7'd0, "R1", "tx_wires", int'(tx_wires), 0);
    chk(rx_ack_out == 1'b0, "R1", "rx_ack_out", int'(rx_ack_out), 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready", int'(tx_ready), 1);
    chk(!rx_valid && !rx_err, "R1", "rx_valid|rx_err", int'({rx_valid, rx_err}), 0);
    prev_tx = tx_wires;
    prev_ack = rx_ack_out;
    prev_dly = ackline[ack_tap];
    mon_on = 1;

    // R3 R5: full table walk, fast wires.
    for (int v = 0; v < 16; v++) send(1'b0, 4'(v));
    send(1'b1, 4'hA);
    settle_idle();

    // R7: skewed data lines and a slow acknowledge.
    skew_mask = 7'b1010101;
    ack_tap = 6;
    prev_dly = ackline[ack_tap];
    settle_idle();
    send(1'b0, 4'd9); send(1'b0, 4'd3); send(1'b0, 4'd15); send(1'b0, 4'd0);
    send(1'b1, 4'd0);
    settle_idle();
    skew_mask = '0;
    ack_tap = 2;
    prev_dly = ackline[ack_tap];
    settle_idle();

    // R8: three-line change between packets; following packet dropped.
    inject(7'b0001011);
    send(1'b0, 4'd7); send(1'b1, 4'd0);
    send(1'b0, 4'd12); send(1'b1, 4'd0);
    settle_idle();

    // R9 R10: unused pair (5,6) inside a packet.
    send(1'b0, 4'd1); send(1'b0, 4'd2);
    inject(7'b1100000);
    send(1'b0, 4'd3); send(1'b0, 4'd4); send(1'b1, 4'd0);
    send(1'b0, 4'd5); send(1'b0, 4'd6); send(1'b1, 4'd0);
    settle_idle();

    chk(exp_q.size() == 0, "R5", "undelivered symbols", exp_q.size(), 0);
    chk(exp_err == 0, "R8", "missing rx_err pulses", exp_err, 0);
    chk(ack_toggles == sym_total, "R6", "ack inversions", ack_toggles, sym_total);
    chk(tx_ready == 1'b1, "R4", "tx_ready at end", int'(tx_ready), 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R4): actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule